// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences the power states of a small microcontroller. From normal operation the CPU can request a deep sleep or a light halt with a one-cycle strobe. In deep sleep the primary oscillator, the system clock, the CPU clock and the program-counter advance are all switched off. Only the low-speed domain keeps running. In halt the oscillator and system clock stay on and only the CPU clock and program-counter advance stop.

Deep sleep ends only through a reset from a qualified source. Every reset, including power-on, passes through a stabilization phase. In that phase the system reset output is held and the oscillator runs, while a counter counts a configurable number of low-speed ticks. The clocks come back only when that count completes. Halt ends with no delay when an unmasked interrupt arrives. A gating register with one bit per peripheral switches individual peripheral clocks off. A cause register records what triggered the most recent reset.

Top module: `lp_wake_ctrl`

## Requirements
- R1: While `por_n` is low and after it is released, the block is in stabilization. `sys_rst` is 1, `osc_en` is 1, `sysclk_en`, `cpuclk_en` and `pc_adv_en` are 0, `rst_cause` is 0 and `gate_q` is all zeros.
- R2: In stabilization, `sys_rst` stays 1 until `STAB_LEN` cycles with `lf_tick` high have been counted. At the clock edge that takes the last tick, the block enters run. In run, `sys_rst` is 0 and `osc_en`, `sysclk_en`, `cpuclk_en` and `pc_adv_en` are all 1.
- R3: `sleep_req` in run enters sleep at the next edge. In sleep, `osc_en`, `sysclk_en`, `cpuclk_en`, `pc_adv_en` and every bit of `per_clk_en` are 0.
- R4: Sleep is left only by a reset request. The valid requests are `pin_rst_n` low, `rtc_alarm`, `dbg_rst` and a qualified brown-out. Interrupts are ignored in sleep. `rtc_alarm` is not a reset source outside sleep. A reset request moves the block to stabilization from any state.
- R5: In sleep, `wdt_timeout` causes a reset only when both `wdt_lf_sel` and `wdt_rst_en` are 1, and is otherwise ignored. Outside sleep, `wdt_rst_en` alone qualifies it.
- R6: `bo_event` causes a reset only when `bo_en` is 1.
- R7: `halt_req` in run enters halt. In halt, `osc_en` and `sysclk_en` stay 1 while `cpuclk_en` and `pc_adv_en` are 0.
- R8: In halt, an interrupt bit of `irq_req` whose `irq_mask` bit is 0 returns the block to run at the next edge, with no stabilization. Interrupts whose mask bit is 1 are ignored.
- R9: `gate_we` in run loads `gate_q` from `gate_wdata`. A 1 in bit i forces `per_clk_en[i]` to 0. When the system clock is on, `per_clk_en` is the inverse of `gate_q`. Every reset clears `gate_q`.
- R10: `rst_cause` codes are 0 for power-on, 1 for pin, 2 for RTC, 3 for watchdog, 4 for debug and 5 for brown-out. If several sources request a reset in the same cycle, the code of the highest-priority source is recorded. The priority, from highest to lowest, is pin, brown-out, watchdog, debug, RTC.
- R11: While `pin_rst_n` stays low, the stabilization count is held at zero. The full `STAB_LEN` ticks are counted only after the pin is released.
- R12: If `sleep_req` and `halt_req` arrive together in run, the block enters sleep. Both requests are ignored outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_req | input | 1 | CPU strobe requesting deep sleep |
| halt_req | input | 1 | CPU strobe requesting halt |
| irq_req | input | IRQ_W | Pending interrupt requests |
| irq_mask | input | IRQ_W | Interrupt masks, 1 = masked |
| pin_rst_n | input | 1 | External reset pin, active low |
| rtc_alarm | input | 1 | Real-time-clock alarm strobe |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| wdt_lf_sel | input | 1 | Watchdog runs from the low-speed clock |
| wdt_rst_en | input | 1 | Watchdog time-out is set to reset |
| dbg_rst | input | 1 | Debug reset command |
| bo_event | input | 1 | Brown-out detection strobe |
| bo_en | input | 1 | Brown-out detection enabled |
| lf_tick | input | 1 | One-cycle tick from the low-speed domain |
| gate_we | input | 1 | Write strobe for the peripheral gating register |
| gate_wdata | input | NPERIPH | Write data for the gating register |
| osc_en | output | 1 | Primary oscillator enable |
| sysclk_en | output | 1 | System clock enable |
| cpuclk_en | output | 1 | CPU clock enable |
| pc_adv_en | output | 1 | Program-counter advance enable |
| sys_rst | output | 1 | System reset, held during stabilization |
| per_clk_en | output | NPERIPH | Per-peripheral clock enables |
| gate_q | output | NPERIPH | Gating register contents |
| rst_cause | output | 3 | Code of the last reset cause |

## Verification
The hardest conditions to reach are the qualified wake paths in sleep. A watchdog time-out must be refused under each partial qualification and then accepted when fully qualified, and these cases can only be seen as an absence of wake. The stimulus first enters sleep and then applies each partial qualification by itself. After each one it confirms that every enable is still off and `sys_rst` is still low. Only then does it complete the qualification. Simultaneous reset sources and a reset pin held low across several ticks are driven in the same way. This shows the priority order and the restart of the count.

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl #(
  parameter int NPERIPH  = 8,
  parameter int IRQ_W    = 4,
  parameter int STAB_LEN = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sleep_req,
  input  logic               halt_req,
  input  logic [IRQ_W-1:0]   irq_req,
  input  logic [IRQ_W-1:0]   irq_mask,
  input  logic               pin_rst_n,
  input  logic               rtc_alarm,
  input  logic               wdt_timeout,
  input  logic               wdt_lf_sel,
  input  logic               wdt_rst_en,
  input  logic               dbg_rst,
  input  logic               bo_event,
  input  logic               bo_en,
  input  logic               lf_tick,
  input  logic               gate_we,
  input  logic [NPERIPH-1:0] gate_wdata,
  output logic               osc_en,
  output logic               sysclk_en,
  output logic               cpuclk_en,
  output logic               pc_adv_en,
  output logic               sys_rst,
  output logic [NPERIPH-1:0] per_clk_en,
  output logic [NPERIPH-1:0] gate_q,
  output logic [2:0]         rst_cause
);

  localparam int CW = (STAB_LEN > 1) ? $clog2(STAB_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_LEN - 1);

  typedef enum logic [1:0] {RUN, HALT, SLEEP, STAB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  logic in_sleep, pin_hit, bo_hit, wdt_hit, dbg_hit, rtc_hit, any_rst, wake_irq;
  logic [2:0] cause_nxt;

  assign in_sleep = (st == SLEEP);
  assign pin_hit  = !pin_rst_n;
  assign bo_hit   = bo_event && bo_en;
  assign wdt_hit  = wdt_timeout && wdt_rst_en && (!in_sleep || wdt_lf_sel);
  assign dbg_hit  = dbg_rst;
  assign rtc_hit  = rtc_alarm && in_sleep;
  assign any_rst  = pin_hit || bo_hit || wdt_hit || dbg_hit || rtc_hit;
  assign wake_irq = |(irq_req & ~irq_mask);

  always_comb begin
    if (pin_hit)      cause_nxt = 3'd1;
    else if (bo_hit)  cause_nxt = 3'd5;
    else if (wdt_hit) cause_nxt = 3'd3;
    else if (dbg_hit) cause_nxt = 3'd4;
    else              cause_nxt = 3'd2;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= STAB;
      cnt       <= '0;
      rst_cause <= 3'd0;
      gate_q    <= '0;
    end else if (any_rst) begin
      st        <= STAB;
      cnt       <= '0;
      rst_cause <= cause_nxt;
      gate_q    <= '0;
    end else begin
      case (st)
        RUN: begin
          if (gate_we) gate_q <= gate_wdata;
          if (sleep_req)     st <= SLEEP;
          else if (halt_req) st <= HALT;
        end
        HALT:  if (wake_irq) st <= RUN;
        SLEEP: ;
        STAB: begin
          if (lf_tick) begin
            if (cnt == LAST) begin
              st  <= RUN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= STAB;
      endcase
    end
  end

  assign osc_en     = (st != SLEEP);
  assign sysclk_en  = (st == RUN) || (st == HALT);
  assign cpuclk_en  = (st == RUN);
  assign pc_adv_en  = (st == RUN);
  assign sys_rst    = (st == STAB);
  assign per_clk_en = sysclk_en ? ~gate_q : '0;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == RUN && sleep_req && !any_rst) |=> (!osc_en && !sysclk_en && !cpuclk_en && per_clk_en == '0));

  // R7
  halt_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == RUN && halt_req && !sleep_req && !any_rst) |=> (osc_en && sysclk_en && !cpuclk_en && !pc_adv_en));

  // R8
  halt_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == HALT && wake_irq && !any_rst) |=> (cpuclk_en && !sys_rst));

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $past(lf_tick));

  // R5
  wdt_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (in_sleep && wdt_timeout && !(wdt_lf_sel && wdt_rst_en) && pin_rst_n && !rtc_alarm && !dbg_rst && !bo_hit)
      |=> (!sys_rst && !osc_en));

  // R9
  gate_applied_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == RUN && gate_we && !sleep_req && !halt_req && !any_rst) |=> ((per_clk_en & $past(gate_wdata)) == '0));

endmodule

// File: tb/lp_wake_ctrl_test.sv
module lp_wake_ctrl_test;
  localparam int NP = 8;
  localparam int IW = 4;
  localparam int SL = 4;

  logic clk = 0;
  logic por_n = 0;
  logic sleep_req = 0, halt_req = 0;
  logic [IW-1:0] irq_req = '0, irq_mask = '0;
  logic pin_rst_n = 1, rtc_alarm = 0, wdt_timeout = 0, wdt_lf_sel = 0, wdt_rst_en = 0;
  logic dbg_rst = 0, bo_event = 0, bo_en = 0, lf_tick = 0, gate_we = 0;
  logic [NP-1:0] gate_wdata = '0;
  logic osc_en, sysclk_en, cpuclk_en, pc_adv_en, sys_rst;
  logic [NP-1:0] per_clk_en, gate_q;
  logic [2:0] rst_cause;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lp_wake_ctrl #(.NPERIPH(NP), .IRQ_W(IW), .STAB_LEN(SL)) uut (
    .clk(clk), .por_n(por_n), .sleep_req(sleep_req), .halt_req(halt_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .pin_rst_n(pin_rst_n), .rtc_alarm(rtc_alarm),
    .wdt_timeout(wdt_timeout), .wdt_lf_sel(wdt_lf_sel), .wdt_rst_en(wdt_rst_en),
    .dbg_rst(dbg_rst), .bo_event(bo_event), .bo_en(bo_en), .lf_tick(lf_tick),
    .gate_we(gate_we), .gate_wdata(gate_wdata), .osc_en(osc_en), .sysclk_en(sysclk_en),
    .cpuclk_en(cpuclk_en), .pc_adv_en(pc_adv_en), .sys_rst(sys_rst),
    .per_clk_en(per_clk_en), .gate_q(gate_q), .rst_cause(rst_cause));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [3:0] en4();
    return {osc_en, sysclk_en, cpuclk_en, pc_adv_en};
  endfunction

  task automatic tick();
    lf_tick = 1; step(); lf_tick = 0;
  endtask

  task automatic release_stab(string tag);
    for (int i = 0; i < SL - 1; i++) begin
      tick();
      step();
    end
    check({tag, " R2 held before last tick"}, sys_rst, 1);
    tick();
    check({tag, " R2 released"}, sys_rst, 0);
    check({tag, " R2 enables on"}, en4(), 4'b1111);
  endtask

  task automatic go_sleep();
    sleep_req = 1; step(); sleep_req = 0;
  endtask

  task automatic t_power_on();
    step(2);
    check("R1 sys_rst in por", sys_rst, 1);
    por_n = 1; step();
    check("R1 sys_rst", sys_rst, 1);
    check("R1 enables", en4(), 4'b1000);
    check("R1 cause", rst_cause, 0);
    check("R1 gate", gate_q, 0);
    release_stab("por");
  endtask

  task automatic t_sleep_rtc();
    go_sleep();
    check("R3 sleep enables", en4(), 4'b0000);
    check("R3 per clocks", per_clk_en, 0);
    irq_req = 4'hF; step(); irq_req = '0;
    check("R4 irq ignored in sleep", {sys_rst, osc_en}, 2'b00);
    rtc_alarm = 1; step(); rtc_alarm = 0;
    check("R4 rtc wake", {sys_rst, osc_en}, 2'b11);
    check("R10 rtc cause", rst_cause, 2);
    release_stab("rtc");
    rtc_alarm = 1; step(); rtc_alarm = 0;
    check("R4 rtc ignored in run", {sys_rst, rst_cause}, {1'b0, 3'd2});
  endtask

  task automatic t_wdt();
    go_sleep();
    wdt_timeout = 1; wdt_rst_en = 1; wdt_lf_sel = 0; step();
    check("R5 wdt no lf sel", {sys_rst, osc_en}, 2'b00);
    wdt_rst_en = 0; wdt_lf_sel = 1; step();
    check("R5 wdt no rst en", {sys_rst, osc_en}, 2'b00);
    wdt_rst_en = 1; step(); wdt_timeout = 0;
    check("R5 wdt qualified wake", sys_rst, 1);
    check("R10 wdt cause", rst_cause, 3);
    release_stab("wdt");
    dbg_rst = 1; step(); dbg_rst = 0;
    check("R10 debug cause", rst_cause, 4);
    release_stab("dbg");
    wdt_lf_sel = 0; wdt_timeout = 1; step(); wdt_timeout = 0;
    check("R5 wdt in run", {sys_rst, rst_cause}, {1'b1, 3'd3});
    wdt_rst_en = 0;
    release_stab("wdt run");
  endtask

  task automatic t_bod();
    go_sleep();
    bo_event = 1; bo_en = 0; step();
    check("R6 bo disabled ignored", {sys_rst, osc_en}, 2'b00);
    bo_en = 1; step(); bo_event = 0;
    check("R6 bo wake", sys_rst, 1);
    check("R10 bo cause", rst_cause, 5);
    bo_en = 0;
    release_stab("bo");
  endtask

  task automatic t_priority();
    pin_rst_n = 0; dbg_rst = 1; step(); dbg_rst = 0; pin_rst_n = 1;
    check("R10 pin over debug", rst_cause, 1);
    release_stab("prio1");
    bo_en = 1; bo_event = 1; wdt_rst_en = 1; wdt_timeout = 1; step();
    bo_event = 0; wdt_timeout = 0; bo_en = 0; wdt_rst_en = 0;
    check("R10 bo over wdt", rst_cause, 5);
    release_stab("prio2");
  endtask

  task automatic t_pin_hold();
    pin_rst_n = 0;
    for (int i = 0; i < SL; i++) begin tick(); step(); end
    check("R11 held while pin low", sys_rst, 1);
    pin_rst_n = 1; step();
    release_stab("R11 pin");
  endtask

  task automatic t_halt();
    halt_req = 1; step(); halt_req = 0;
    check("R7 halt enables", en4(), 4'b1100);
    irq_mask = 4'b0100; irq_req = 4'b0100; step();
    check("R8 masked irq ignored", cpuclk_en, 0);
    irq_req = 4'b0110; step(); irq_req = '0; irq_mask = '0;
    check("R8 unmasked irq wake", {cpuclk_en, sys_rst}, 2'b10);
  endtask

  task automatic t_both_req();
    sleep_req = 1; halt_req = 1; step(); sleep_req = 0; halt_req = 0;
    check("R12 sleep wins", en4(), 4'b0000);
    halt_req = 1; step(); halt_req = 0;
    check("R12 halt ignored in sleep", en4(), 4'b0000);
    dbg_rst = 1; step(); dbg_rst = 0;
    release_stab("R12");
  endtask

  task automatic t_gate();
    gate_wdata = 8'hA5; gate_we = 1; step(); gate_we = 0;
    check("R9 gate value", gate_q, 8'hA5);
    check("R9 per clocks", per_clk_en, 8'h5A);
    dbg_rst = 1; step(); dbg_rst = 0;
    check("R9 gate cleared by reset", gate_q, 0);
    release_stab("gate");
    check("R9 per clocks after reset", per_clk_en, 8'hFF);
  endtask

  initial begin
    t_power_on();
    t_sleep_rtc();
    t_wdt();
    t_bod();
    t_priority();
    t_pin_hold();
    t_halt();
    t_both_req();
    t_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule